// File: doc/BRIEF.md
# Banked Multi-Width Register File

This block is the byte-addressed register file of a small microcontroller core. The register-side port addresses 64 slots with a 6-bit address. In one cycle it reads or writes a single byte, a 16-bit word or a 32-bit dword, or it sets or clears one bit of a byte. Slots 8 to 31 and 56 to 63 are flip-flop registers inside the core. Slots 32 to 55 form a reserved gap with no storage behind it.

Slots 0 to 7 have no storage of their own. They are a window onto one of four eight-byte banks, and a 2-bit bank select input chooses which bank the window shows. The four banks are also the lowest 32 bytes of on-chip data RAM. A separate byte-wide memory port reaches those 32 bytes directly at addresses 00h to 1Fh, whatever the bank select value. Changing the select value gives the core a quick context switch with no copying.

Reads on both ports are combinational. Writes on both ports take effect at the rising clock edge.

Top module: `bankreg_file`

## Requirements
- R1: A byte written through the register port at a core register slot (8 to 31 or 56 to 63) reads back unchanged from the next cycle on. `reg_size` encodes 0 = bit, 1 = byte, 2 = word, 3 = dword.
- R2: Slots 0 to 7 map to RAM byte `bank_sel*8 + slot`. Select 0 shows RAM 00h to 07h, 1 shows 08h to 0Fh, 2 shows 10h to 17h and 3 shows 18h to 1Fh.
- R3: `mem_rdata` always shows RAM byte `mem_addr`, for any bank select value. A `mem_we` write lands at the clock edge.
- R4: Core register slots hold their contents, and read the same, whatever the bank select value.
- R5: A byte that falls in slots 32 to 55 reads as zero and sets `reg_err`. A write to it changes nothing.
- R6: Word and dword data are big-endian: the byte at the lowest slot sits in the most significant byte of the data. A word uses `reg_rdata[15:0]`, and the unused upper bits read zero.
- R7: A word at an odd slot, or a dword at a slot that is not a multiple of four, is misaligned. It sets `reg_err`, returns zero and writes nothing.
- R8: A bit access uses `bit_idx` (0 = least significant bit) and `bit_val`. A write changes only that bit of the byte. A read returns the bit in `reg_rdata[0]` with all other bits zero.
- R9: When the register port and the memory port write the same RAM byte in one cycle, the register port's value is kept.
- R10: A synchronous reset clears every core register slot to zero.
- R11: `reg_err` is high only during a request (`reg_req`). With no request, `reg_rdata` is zero and nothing is written through the register port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the core register slots |
| bank_sel | input | 2 | Bank shown in slots 0 to 7 |
| reg_req | input | 1 | Register-port access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access width: 0 bit, 1 byte, 2 word, 3 dword |
| reg_addr | input | 6 | Lowest slot of the access |
| reg_wdata | input | 32 | Write data, right-aligned, big-endian |
| bit_idx | input | 3 | Bit position for bit accesses |
| bit_val | input | 1 | Value written by a bit write |
| reg_rdata | output | 32 | Combinational read data |
| reg_err | output | 1 | Access touched the gap or was misaligned |
| mem_we | input | 1 | Memory-port byte write |
| mem_addr | input | 5 | Memory-port RAM byte address |
| mem_wdata | input | 8 | Memory-port write data |
| mem_rdata | output | 8 | Combinational memory-port read data |

## Verification
The hardest case to reach is a same-cycle write collision: the register port, through whichever bank is selected, and the memory port must target the same physical RAM byte. Random stimulus rarely lines up all three of bank select, slot and memory address. A directed cycle therefore selects bank 2, writes slot 1 and writes memory byte 11h in the same cycle. The random phase then adds further chance collisions. The bench model resolves every window access through the bank select itself, so a wrong bank mapping shows up either on the memory port or on a later read through a different select value.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  typedef enum logic [1:0] {
    ACC_BIT   = 2'd0,
    ACC_BYTE  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;

  // Number of byte lanes an access spans.
  function automatic int acc_bytes(acc_size_e s);
    case (s)
      ACC_WORD:  return 2;
      ACC_DWORD: return 4;
      default:   return 1;
    endcase
  endfunction

  // Words need an even slot, dwords a slot that is a multiple of four.
  function automatic logic acc_misaligned(acc_size_e s, logic [1:0] lo);
    return (s == ACC_WORD && lo[0]) || (s == ACC_DWORD && lo != 2'b00);
  endfunction

  // Returns byte b with bit i replaced by v.
  function automatic logic [7:0] byte_with_bit(logic [7:0] b, logic [2:0] i, logic v);
    logic [7:0] r;
    r = b;
    r[i] = v;
    return r;
  endfunction

  // Byte lane k of an n-byte big-endian value held right-aligned in d.
  function automatic logic [7:0] pick_lane(logic [31:0] d, int n, int k);
    if (k >= n) return 8'h00;
    return d[8*(n-1-k) +: 8];
  endfunction

endpackage

// File: rtl/bankreg_lane_dec.sv
module bankreg_lane_dec #(
  parameter int ADDR_W     = 6,
  parameter int SEL_W      = 2,
  parameter int BANK_BYTES = 8,
  parameter int HOLE_LO    = 32,
  parameter int HOLE_HI    = 55,
  parameter int RAM_AW     = 5,
  parameter int CPU_AW     = 5
) (
  input  logic [ADDR_W-1:0] slot,
  input  logic [SEL_W-1:0]  bank_sel,
  output logic              in_hole,
  output logic              in_win,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [CPU_AW-1:0] cpu_idx
);
  localparam int OFF_W = $clog2(BANK_BYTES);
  localparam logic [ADDR_W-1:0] LO_BASE = ADDR_W'(BANK_BYTES);
  localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'(HOLE_HI + 1 - HOLE_LO + BANK_BYTES);

  assign in_hole = (slot >= ADDR_W'(HOLE_LO)) && (slot <= ADDR_W'(HOLE_HI));
  assign in_win  = slot < ADDR_W'(BANK_BYTES);
  assign ram_idx = {bank_sel, slot[OFF_W-1:0]};
  assign cpu_idx = (slot < ADDR_W'(HOLE_LO)) ? CPU_AW'(slot - LO_BASE)
                                             : CPU_AW'(slot - HI_BASE);
endmodule

// File: rtl/bankreg_bank_ram.sv
module bankreg_bank_ram #(
  parameter int RAM_AW = 5,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          mem_we,
  input  logic [RAM_AW-1:0]             mem_addr,
  input  logic [7:0]                    mem_wdata,
  output logic [7:0]                    mem_rdata,
  input  logic [LANES-1:0]              lane_we,
  input  logic [LANES-1:0][RAM_AW-1:0]  lane_idx,
  input  logic [LANES-1:0][7:0]         lane_data,
  output logic [(8<<RAM_AW)-1:0]        ram_q
);
  localparam int RAM_BYTES = 1 << RAM_AW;
  logic [7:0] mem [RAM_BYTES];

  // Register-port lanes are applied after the memory port, so they win.
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    for (int k = 0; k < LANES; k++)
      if (lane_we[k]) mem[lane_idx[k]] <= lane_data[k];
  end

  assign mem_rdata = mem[mem_addr];

  for (genvar i = 0; i < RAM_BYTES; i++) begin : g_flat
    assign ram_q[8*i +: 8] = mem[i];
  end
endmodule

// File: rtl/bankreg_cpu_regs.sv
module bankreg_cpu_regs #(
  parameter int CPU_BYTES = 32,
  parameter int CPU_AW    = 5,
  parameter int LANES     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0]              lane_we,
  input  logic [LANES-1:0][CPU_AW-1:0]  lane_idx,
  input  logic [LANES-1:0][7:0]         lane_data,
  output logic [CPU_BYTES*8-1:0]        cpu_q
);
  logic [7:0] regs [CPU_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CPU_BYTES; i++) regs[i] <= 8'h00;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (lane_we[k]) regs[lane_idx[k]] <= lane_data[k];
    end
  end

  for (genvar i = 0; i < CPU_BYTES; i++) begin : g_flat
    assign cpu_q[8*i +: 8] = regs[i];
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SEL_W      = 2,
  parameter int BANK_BYTES = 8,
  parameter int HOLE_LO    = 32,
  parameter int HOLE_HI    = 55,
  parameter int RAM_AW     = SEL_W + $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [1:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              mem_we,
  input  logic [RAM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata
);
  localparam int LANES     = 4;
  localparam int RAM_BYTES = 1 << RAM_AW;
  localparam int CPU_BYTES = (HOLE_LO - BANK_BYTES) + ((1 << ADDR_W) - 1 - HOLE_HI);
  localparam int CPU_AW    = $clog2(CPU_BYTES);

  acc_size_e size_e;
  int        nbytes;
  logic      misalign;
  logic      hole_hit;
  logic      wr_go;

  logic [LANES-1:0]             lane_on, lane_hole, lane_win, lane_we;
  logic [LANES-1:0]             lane_ram_we, lane_cpu_we;
  logic [LANES-1:0][RAM_AW-1:0] lane_ram_idx;
  logic [LANES-1:0][CPU_AW-1:0] lane_cpu_idx;
  logic [LANES-1:0][7:0]        lane_cur, lane_wbyte;
  logic [RAM_BYTES*8-1:0]       ram_q;
  logic [CPU_BYTES*8-1:0]       cpu_q;

  assign size_e   = acc_size_e'(reg_size);
  assign nbytes   = acc_bytes(size_e);
  assign misalign = reg_req && acc_misaligned(size_e, reg_addr[1:0]);
  assign wr_go    = reg_req && reg_wr && !misalign;
  assign hole_hit = |(lane_on & lane_hole);
  assign reg_err  = misalign || hole_hit;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bankreg_lane_dec #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BANK_BYTES(BANK_BYTES),
      .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI), .RAM_AW(RAM_AW), .CPU_AW(CPU_AW)
    ) u_dec (
      .slot    (reg_addr + ADDR_W'(k)),
      .bank_sel(bank_sel),
      .in_hole (lane_hole[k]),
      .in_win  (lane_win[k]),
      .ram_idx (lane_ram_idx[k]),
      .cpu_idx (lane_cpu_idx[k])
    );

    assign lane_on[k]  = reg_req && (k < nbytes);
    assign lane_cur[k] = lane_hole[k] ? 8'h00 :
                         lane_win[k]  ? ram_q[int'(lane_ram_idx[k])*8 +: 8]
                                      : cpu_q[int'(lane_cpu_idx[k])*8 +: 8];
    assign lane_we[k]     = wr_go && lane_on[k] && !lane_hole[k];
    assign lane_ram_we[k] = lane_we[k] && lane_win[k];
    assign lane_cpu_we[k] = lane_we[k] && !lane_win[k];
    assign lane_wbyte[k]  = (size_e == ACC_BIT)
                          ? byte_with_bit(lane_cur[0], bit_idx, bit_val)
                          : pick_lane(reg_wdata, nbytes, k);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_req && !misalign) begin
      if (size_e == ACC_BIT) begin
        reg_rdata[0] = lane_cur[0][bit_idx];
      end else begin
        for (int k = 0; k < LANES; k++)
          if (k < nbytes) reg_rdata[8*(nbytes-1-k) +: 8] = lane_cur[k];
      end
    end
  end

  bankreg_bank_ram #(.RAM_AW(RAM_AW), .LANES(LANES)) u_ram (
    .clk      (clk),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .lane_we  (lane_ram_we),
    .lane_idx (lane_ram_idx),
    .lane_data(lane_wbyte),
    .ram_q    (ram_q)
  );

  bankreg_cpu_regs #(.CPU_BYTES(CPU_BYTES), .CPU_AW(CPU_AW), .LANES(LANES)) u_cpu (
    .clk      (clk),
    .rst      (rst),
    .lane_we  (lane_cpu_we),
    .lane_idx (lane_cpu_idx),
    .lane_data(lane_wbyte),
    .cpu_q    (cpu_q)
  );
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
  parameter int ADDR_W  = 6,
  parameter int HOLE_LO = 32,
  parameter int HOLE_HI = 55,
  parameter int RAM_AW  = 5,
  parameter int LANES   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_req,
  input logic [1:0]        reg_size,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              reg_err,
  input logic              mem_we,
  input logic [RAM_AW-1:0] mem_addr,
  input logic [7:0]        mem_rdata,
  input logic [LANES-1:0]  lane_we
);
  logic port_misaligned;
  logic port_hole_byte;
  assign port_misaligned = (reg_size == 2'd2 && reg_addr[0]) ||
                           (reg_size == 2'd3 && reg_addr[1:0] != 2'b00);
  assign port_hole_byte  = reg_size == 2'd1 &&
                           reg_addr >= ADDR_W'(HOLE_LO) && reg_addr <= ADDR_W'(HOLE_HI);

  // R5
  a_r5_hole_byte_zero: assert property (@(posedge clk) disable iff (rst)
    reg_req && port_hole_byte |-> reg_err && reg_rdata == 32'h0 && lane_we == '0);

  // R7
  a_r7_misalign_blocks: assert property (@(posedge clk) disable iff (rst)
    reg_req && port_misaligned |-> reg_err && reg_rdata == 32'h0 && lane_we == '0);

  // R11
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !reg_req |-> !reg_err && reg_rdata == 32'h0 && lane_we == '0);

  // R3
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_we) && $past(lane_we) == '0 && $stable(mem_addr) |-> $stable(mem_rdata));

  // R8
  a_r8_bit_narrow: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_size == 2'd0 |-> reg_rdata[31:1] == 31'h0);

  // R6
  a_r6_word_narrow: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_size == 2'd2 |-> reg_rdata[31:16] == 16'h0);
endmodule

bind bankreg_file bankreg_file_chk #(
  .ADDR_W(ADDR_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI), .RAM_AW(RAM_AW), .LANES(4)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_req  (reg_req),
  .reg_size (reg_size),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .reg_err  (reg_err),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_rdata(mem_rdata),
  .lane_we  (lane_we)
);

// File: tb/test_bankreg_file.sv
`timescale 1ns/1ps
module test_bankreg_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bank_sel = '0;
  logic        reg_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_size = 2'd1;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  bit_idx = '0;
  logic        bit_val = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        mem_we = 1'b0;
  logic [4:0]  mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bankreg_file i_bankreg_file (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bit_idx(bit_idx), .bit_val(bit_val), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural model: byte arrays indexed by slot and by RAM address.
  logic [7:0] cpu_m [64];
  logic [7:0] ram_m [32];

  function automatic bit m_hole(int s); return s >= 32 && s <= 55; endfunction
  function automatic logic [7:0] m_get(int s, int sel);
    if (m_hole(s)) return 8'h00;
    if (s < 8) return ram_m[sel*8 + s];
    return cpu_m[s];
  endfunction
  function automatic int m_n(int sz); return sz == 3 ? 4 : (sz == 2 ? 2 : 1); endfunction
  function automatic bit m_mis(int sz, int a);
    return (sz == 2 && a % 2 != 0) || (sz == 3 && a % 4 != 0);
  endfunction
  function automatic string auto_tag(int sz, int a);
    if (m_mis(sz, a)) return "R7";
    for (int k = 0; k < m_n(sz); k++) if (m_hole(a + k)) return "R5";
    if (sz == 0) return "R8";
    if (sz >= 2) return "R6";
    if (a < 8) return "R2";
    return "R1";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock cycle: drive, compare before the edge, then update the model.
  task automatic cyc(bit req, bit wr, int sz, int a, logic [31:0] wd, int bi, bit bv,
                     int sel, bit mwe, int ma, logic [7:0] mwd, string tag);
    int n; bit mis; bit herr; logic [31:0] er; logic [7:0] b;
    int ws [4]; logic [7:0] wv [4]; int wc;
    string t;
    bank_sel = 2'(sel); reg_req = req; reg_wr = wr; reg_size = 2'(sz);
    reg_addr = 6'(a); reg_wdata = wd; bit_idx = 3'(bi); bit_val = bv;
    mem_we = mwe; mem_addr = 5'(ma); mem_wdata = mwd;
    #2;
    t = (tag == "") ? auto_tag(sz, a) : tag;
    n = m_n(sz); mis = m_mis(sz, a); herr = 0; er = 0; wc = 0;
    for (int k = 0; k < n; k++) if (m_hole(a + k)) herr = 1;
    if (req && !mis) begin
      if (sz == 0) er[0] = m_get(a, sel)[bi];
      else for (int k = 0; k < n; k++) er[8*(n-1-k) +: 8] = m_get(a + k, sel);
    end
    chk(req ? t : "R11", "reg_rdata", reg_rdata, er);
    chk(req ? t : "R11", "reg_err", {31'h0, reg_err}, {31'h0, req && (mis || herr)});
    chk("R3", "mem_rdata", {24'h0, mem_rdata}, {24'h0, ram_m[ma]});
    if (req && wr && !mis) begin
      for (int k = 0; k < n; k++) begin
        if (!m_hole(a + k)) begin
          if (sz == 0) begin b = m_get(a, sel); b[bi] = bv; end
          else b = wd[8*(n-1-k) +: 8];
          ws[wc] = a + k; wv[wc] = b; wc++;
        end
      end
    end
    @(posedge clk);
    if (mwe) ram_m[ma] = mwd;
    for (int k = 0; k < wc; k++) begin
      if (ws[k] < 8) ram_m[sel*8 + ws[k]] = wv[k];
      else cpu_m[ws[k]] = wv[k];
    end
    #1;
  endtask

  task automatic rd(int sz, int a, int sel, string tag);
    cyc(1, 0, sz, a, 0, 0, 0, sel, 0, 0, 0, tag);
  endtask
  task automatic wrb(int sz, int a, logic [31:0] d, int sel, string tag);
    cyc(1, 1, sz, a, d, 0, 0, sel, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 64; i++) cpu_m[i] = 8'h00;
    for (int i = 0; i < 32; i++) ram_m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: core registers read zero after reset
    rd(1, 8, 0, "R10"); rd(2, 30, 1, "R10"); rd(3, 56, 2, "R10"); rd(1, 63, 3, "R10");
    // R3: fill RAM through the memory port
    for (int i = 0; i < 32; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, i, 8'(i*7 + 3), "R3");
    for (int i = 0; i < 32; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, i, 0, "R3");
    // R2: each bank through the window
    for (int b = 0; b < 4; b++) begin rd(3, 0, b, "R2"); rd(3, 4, b, "R2"); end
    wrb(1, 5, 32'hC3, 3, "R2");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 29, 0, "R2");
    // R1 / R4: core slots independent of bank select
    wrb(1, 9, 32'h5A, 0, "R1"); rd(1, 9, 3, "R4"); rd(1, 9, 1, "R4");
    wrb(3, 60, 32'h11223344, 2, "R6"); rd(1, 60, 0, "R6"); rd(2, 62, 1, "R6");
    // R5: reserved gap
    wrb(1, 40, 32'hFF, 0, "R5"); rd(1, 40, 0, "R5"); wrb(3, 32, 32'hDEADBEEF, 0, "R5");
    rd(3, 32, 0, "R5"); rd(2, 54, 0, "R5"); rd(1, 31, 0, "R5");
    // R7: misaligned word write has no effect
    wrb(2, 11, 32'hABCD, 0, "R7"); rd(1, 11, 0, "R7"); rd(1, 12, 0, "R7");
    wrb(3, 18, 32'h01020304, 0, "R7"); rd(3, 16, 0, "R7"); rd(3, 20, 0, "R7");
    // R8: single-bit set and clear
    wrb(1, 20, 32'h00, 0, "R8");
    cyc(1, 1, 0, 20, 0, 5, 1, 0, 0, 0, 0, "R8"); rd(1, 20, 0, "R8");
    cyc(1, 1, 0, 3, 0, 0, 0, 1, 0, 0, 0, "R8"); rd(1, 3, 1, "R8");
    cyc(1, 0, 0, 3, 0, 1, 0, 1, 0, 0, 0, "R8");
    // R9: both ports write RAM byte 11h in one cycle
    cyc(1, 1, 1, 1, 32'hAA, 0, 0, 2, 1, 17, 8'h55, "R9");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 17, 0, "R9"); rd(1, 1, 2, "R9");
    // Mixed random traffic
    s = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      cyc(s[3:0] != 0, s[4], int'(s[6:5]), int'(s[12:7]), {s[31:16], s[15:0] ^ 16'h3C5A},
          int'(s[15:13]), s[16], int'(s[18:17]), s[21:19] == 0, int'(s[26:22]),
          s[31:24], "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule